// File: doc/BRIEF.md
# Conversion Start Trigger Selector

This block decides the cycle in which a single, non-burst analog conversion begins. A 3-bit start code chooses one of three behaviours: never start, start at once, or wait for an edge on one of six external trigger lines. The six lines are two pad signals and four timer compare outputs. A polarity bit chooses whether a rising or a falling edge counts. The block sends a one-cycle start pulse to the conversion sequencer.

Every trigger line passes through its own synchronizer. The chosen line is exclusive-ORed with the polarity bit, and one rising-edge detector watches the result. The configuration is loaded by a local control write, or by a global start write. The global write is wired to two converters, so both load the same settings and start in the same cycle. Every write reloads the edge detector's history with the level that the new setting selects. Because of this, changing the code or the polarity never makes a false edge.

Top module: `conv_start_sel`

## Requirements
- R1: While reset is high and in the first cycle after it, `start_o` is 0. The loaded start code after reset is 000, so no trigger activity produces a pulse until a write.
- R2: With start code 000 loaded, `start_o` stays 0 whatever the trigger lines do.
- R3: A write of code 001 with burst 0 produces exactly one `start_o` pulse. The pulse is high in the cycle after the write edge. No further pulse follows while the code stays loaded.
- R4: Codes 010 to 111 select trigger line `trig_in[code-2]`. Code 010 selects bit 0 and code 111 selects bit 5. Activity on lines that are not selected produces no pulse.
- R5: With a trigger code loaded and the fall bit at 0, a rising edge on the selected line produces one pulse. Say the line's new level is first sampled at clock edge n. Then `start_o` is high in the cycle after edge n+2. A falling edge produces nothing.
- R6: With the fall bit at 1, a falling edge on the selected line produces one pulse, with the same latency. A rising edge produces nothing.
- R7: The fall bit has no effect for codes 000 and 001.
- R8: When the burst bit of a write is 1, no pulse is produced for any code, including 001 and the trigger codes.
- R9: A write never produces a pulse from the trigger path. This holds even when the new code or polarity makes the selected level differ from the previous one. The level present at the write becomes the reference for the next edge.
- R10: A global write loads its own code, fall and burst fields. It starts every converter that shares it in the same cycle. If a local write happens in the same cycle, the global write wins.
- R11: A trigger level held for many cycles gives a pulse only one cycle wide, once per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Local control write strobe |
| ctrl_mode | input | 3 | Start code for a local write |
| ctrl_fall | input | 1 | Polarity for a local write (1 = falling) |
| ctrl_burst | input | 1 | Burst flag for a local write |
| glob_wr | input | 1 | Global start write strobe shared by converters |
| glob_mode | input | 3 | Start code for a global write |
| glob_fall | input | 1 | Polarity for a global write |
| glob_burst | input | 1 | Burst flag for a global write |
| trig_in | input | 6 | Asynchronous trigger lines; bit k is selected by code k+2 |
| start_o | output | 1 | One-cycle conversion start pulse |

## Verification
The result of an immediate start registers on the write edge, so it is due one cycle after the write. A trigger edge is due three edges after the new level is first sampled: two synchronizer stages and then the output register. The bench drives inputs on the falling clock edge. A behavioural model advances on each rising edge, and the bench compares `start_o` with the model at every falling edge, so each comparison reads a value that settled half a cycle earlier. The directed scenarios also count pulses over windows longer than the latency. This catches missing, extra and widened pulses. It also checks that two converters sharing the global strobe pulse in the same cycle.

// File: rtl/cst_pkg.sv
package cst_pkg;

    localparam int unsigned NUM_SRC   = 6;
    localparam int unsigned CODE_W    = 3;
    localparam int unsigned SRC_IDX_W = $clog2(NUM_SRC);

    typedef enum logic [CODE_W-1:0] {
        START_NONE = 3'd0,
        START_NOW  = 3'd1,
        START_T0   = 3'd2,
        START_T1   = 3'd3,
        START_T2   = 3'd4,
        START_T3   = 3'd5,
        START_T4   = 3'd6,
        START_T5   = 3'd7
    } start_code_e;

    typedef struct packed {
        logic        burst;
        logic        fall;
        start_code_e code;
    } start_cfg_t;

    localparam start_cfg_t CFG_RESET = '{burst: 1'b0, fall: 1'b0, code: START_NONE};

    function automatic logic is_trig_code(input start_code_e c);
        return (c != START_NONE) && (c != START_NOW);
    endfunction

    function automatic logic [SRC_IDX_W-1:0] src_index(input start_code_e c);
        logic [CODE_W-1:0] raw;
        raw = c;
        if (is_trig_code(c))
            return SRC_IDX_W'(raw - CODE_W'(2));
        return '0;
    endfunction

    function automatic logic pick_level(input logic [NUM_SRC-1:0] lines,
                                        input start_cfg_t cfg);
        return lines[src_index(cfg.code)] ^ cfg.fall;
    endfunction

endpackage

// File: rtl/cst_sync.sv
module cst_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[LAST];
endmodule

// File: rtl/cst_cfg_reg.sv
module cst_cfg_reg
    import cst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  start_cfg_t ctrl_cfg,
    input  logic       glob_wr,
    input  start_cfg_t glob_cfg,
    output start_cfg_t cfg_q,
    output start_cfg_t cfg_next,
    output logic       wr_any,
    output logic       imm_fire
);
    always_comb begin
        wr_any   = ctrl_wr | glob_wr;
        cfg_next = glob_wr ? glob_cfg : ctrl_cfg;
        imm_fire = wr_any && (cfg_next.code == START_NOW) && !cfg_next.burst;
    end

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (wr_any) cfg_q <= cfg_next;
    end
endmodule

// File: rtl/cst_edge_det.sv
module cst_edge_det
    import cst_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] lines,
    input  start_cfg_t         cfg_cur,
    input  start_cfg_t         cfg_new,
    input  logic               reload,
    output logic               rise
);
    logic lvl_cur;
    logic lvl_new;
    logic hist_q;
    logic armed;

    always_comb begin
        lvl_cur = pick_level(lines, cfg_cur);
        lvl_new = pick_level(lines, cfg_new);
        armed   = is_trig_code(cfg_cur.code) && !cfg_cur.burst;
        rise    = armed && lvl_cur && !hist_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         hist_q <= 1'b0;
        else if (reload) hist_q <= lvl_new;
        else             hist_q <= lvl_cur;
    end
endmodule

// File: rtl/conv_start_sel.sv
module conv_start_sel
    import cst_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr,
    input  logic [CODE_W-1:0]  ctrl_mode,
    input  logic               ctrl_fall,
    input  logic               ctrl_burst,
    input  logic               glob_wr,
    input  logic [CODE_W-1:0]  glob_mode,
    input  logic               glob_fall,
    input  logic               glob_burst,
    input  logic [NUM_SRC-1:0] trig_in,
    output logic               start_o
);
    start_cfg_t         ctrl_cfg;
    start_cfg_t         glob_cfg;
    start_cfg_t         cfg_q;
    start_cfg_t         cfg_next;
    logic               wr_any;
    logic               imm_fire;
    logic [NUM_SRC-1:0] trig_sync;
    logic               trig_rise;

    always_comb begin
        ctrl_cfg.burst = ctrl_burst;
        ctrl_cfg.fall  = ctrl_fall;
        ctrl_cfg.code  = start_code_e'(ctrl_mode);
        glob_cfg.burst = glob_burst;
        glob_cfg.fall  = glob_fall;
        glob_cfg.code  = start_code_e'(glob_mode);
    end

    cst_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (trig_in),
        .d_out (trig_sync)
    );

    cst_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .ctrl_cfg (ctrl_cfg),
        .glob_wr  (glob_wr),
        .glob_cfg (glob_cfg),
        .cfg_q    (cfg_q),
        .cfg_next (cfg_next),
        .wr_any   (wr_any),
        .imm_fire (imm_fire)
    );

    cst_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .lines   (trig_sync),
        .cfg_cur (cfg_q),
        .cfg_new (cfg_next),
        .reload  (wr_any),
        .rise    (trig_rise)
    );

    always_ff @(posedge clk) begin
        if (rst)         start_o <= 1'b0;
        else if (wr_any) start_o <= imm_fire;
        else             start_o <= trig_rise;
    end
endmodule

// File: rtl/conv_start_sel_chk.sv
module conv_start_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_wr,
    input logic [2:0] ctrl_mode,
    input logic       ctrl_burst,
    input logic       glob_wr,
    input logic [2:0] glob_mode,
    input logic       glob_burst,
    input logic       start_o
);
    // R1
    out_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !start_o);

    // R2
    no_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !glob_wr && ctrl_mode == 3'd0) |=> !start_o);

    // R3
    imm_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !glob_wr && ctrl_mode == 3'd1 && !ctrl_burst) |=> start_o);

    // R8
    burst_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !glob_wr && ctrl_burst) |=> !start_o);

    // R10
    glob_start_chk: assert property (@(posedge clk) disable iff (rst)
        (glob_wr && glob_mode == 3'd1 && !glob_burst) |=> start_o);

    // R10
    glob_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (glob_wr && glob_burst) |=> !start_o);
endmodule

bind conv_start_sel conv_start_sel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .ctrl_mode  (ctrl_mode),
    .ctrl_burst (ctrl_burst),
    .glob_wr    (glob_wr),
    .glob_mode  (glob_mode),
    .glob_burst (glob_burst),
    .start_o    (start_o)
);

// File: tb/conv_start_sel_bench.sv
module conv_start_sel_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [2:0] ctrl_mode = 3'd0;
    logic       ctrl_fall = 1'b0;
    logic       ctrl_burst = 1'b0;
    logic       glob_wr = 1'b0;
    logic [2:0] glob_mode = 3'd0;
    logic       glob_fall = 1'b0;
    logic       glob_burst = 1'b0;
    logic [5:0] trig_in = 6'd0;
    logic       start_a;
    logic       start_b;

    int    n_checks = 0;
    int    n_fail = 0;
    int    pulses = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // model state
    logic [5:0] m_s1 = 6'd0;
    logic [5:0] m_s2 = 6'd0;
    int         m_code = 0;
    logic       m_fall = 1'b0;
    logic       m_burst = 1'b0;
    logic       m_hist = 1'b0;
    logic       m_start = 1'b0;

    always #5 clk = ~clk;

    conv_start_sel u_conv_start_sel (
        .clk(clk), .rst(rst),
        .ctrl_wr(ctrl_wr), .ctrl_mode(ctrl_mode), .ctrl_fall(ctrl_fall), .ctrl_burst(ctrl_burst),
        .glob_wr(glob_wr), .glob_mode(glob_mode), .glob_fall(glob_fall), .glob_burst(glob_burst),
        .trig_in(trig_in), .start_o(start_a)
    );

    // second converter sharing the global strobe and the trigger lines
    conv_start_sel u_conv_start_sel_b (
        .clk(clk), .rst(rst),
        .ctrl_wr(1'b0), .ctrl_mode(3'd0), .ctrl_fall(1'b0), .ctrl_burst(1'b0),
        .glob_wr(glob_wr), .glob_mode(glob_mode), .glob_fall(glob_fall), .glob_burst(glob_burst),
        .trig_in(trig_in), .start_o(start_b)
    );

    function automatic logic lvl_of(logic [5:0] s, int code, logic fall);
        if (code >= 2) return s[code-2] ^ fall;
        return 1'b0;
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_code = 0; m_fall = 0; m_burst = 0; m_hist = 0; m_start = 0;
        end else begin
            if (glob_wr || ctrl_wr) begin
                m_code  = glob_wr ? int'(glob_mode) : int'(ctrl_mode);
                m_fall  = glob_wr ? glob_fall : ctrl_fall;
                m_burst = glob_wr ? glob_burst : ctrl_burst;
                m_start = (m_code == 1) && !m_burst;
                m_hist  = lvl_of(m_s2, m_code, m_fall);
            end else begin
                m_start = (m_code >= 2) && !m_burst && lvl_of(m_s2, m_code, m_fall) && !m_hist;
                m_hist  = lvl_of(m_s2, m_code, m_fall);
            end
            m_s2 = m_s1;
            m_s1 = trig_in;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, start_a, m_start);
            if (start_a) pulses++;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_local(logic [2:0] mode, logic fall, logic burst);
        @(negedge clk);
        ctrl_wr = 1; ctrl_mode = mode; ctrl_fall = fall; ctrl_burst = burst;
        @(negedge clk);
        ctrl_wr = 0;
    endtask

    initial begin
        int base;
        step(3);
        rst = 0;
        cur_req = "R1";
        @(negedge clk);
        chk("R1", start_a, 1'b0);
        trig_in = 6'h3F; step(6); trig_in = 6'h00; step(6);
        chk_int("R1", pulses, 0);

        cur_req = "R2";
        wr_local(3'd0, 1'b0, 1'b0);
        base = pulses;
        for (int k = 0; k < 4; k++) begin trig_in = ~trig_in; step(5); end
        chk_int("R2", pulses - base, 0);
        trig_in = 0; step(4);

        cur_req = "R3";
        base = pulses;
        wr_local(3'd1, 1'b0, 1'b0);
        chk("R3", start_a, 1'b1);
        step(1);
        chk("R3", start_a, 1'b0);
        trig_in = 6'h3F; step(10); trig_in = 0; step(6);
        chk_int("R3", pulses - base, 1);

        cur_req = "R7";
        base = pulses;
        wr_local(3'd1, 1'b1, 1'b0);
        chk("R7", start_a, 1'b1);
        wr_local(3'd0, 1'b1, 1'b0);
        trig_in = 6'h3F; step(6); trig_in = 0; step(6);
        chk_int("R7", pulses - base, 1);

        for (int c = 2; c < 8; c++) begin
            cur_req = "R4";
            trig_in = 0; step(4);
            wr_local(3'(c), 1'b0, 1'b0);
            base = pulses;
            trig_in = ~(6'd1 << (c-2)); step(6);
            trig_in = 0; step(6);
            chk_int("R4", pulses - base, 0);
            cur_req = "R5";
            base = pulses;
            trig_in[c-2] = 1'b1;
            step(2);
            chk("R5", start_a, 1'b0);
            step(1);
            chk("R5", start_a, 1'b1);
            step(5);
            trig_in[c-2] = 1'b0; step(6);
            chk_int("R5", pulses - base, 1);
        end

        cur_req = "R6";
        trig_in = 6'h01; step(4);
        wr_local(3'd2, 1'b1, 1'b0);
        base = pulses;
        trig_in = 0; step(2);
        chk("R6", start_a, 1'b0);
        step(1);
        chk("R6", start_a, 1'b1);
        step(4);
        trig_in = 6'h01; step(6);
        chk_int("R6", pulses - base, 1);

        cur_req = "R9";
        base = pulses;
        wr_local(3'd2, 1'b0, 1'b0);
        step(5);
        wr_local(3'd2, 1'b1, 1'b0);
        step(5);
        wr_local(3'd3, 1'b1, 1'b0);
        step(5);
        wr_local(3'd2, 1'b0, 1'b0);
        step(5);
        chk_int("R9", pulses - base, 0);

        cur_req = "R8";
        trig_in = 0; step(4);
        base = pulses;
        wr_local(3'd1, 1'b0, 1'b1);
        chk("R8", start_a, 1'b0);
        wr_local(3'd2, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) begin trig_in = ~trig_in; step(5); end
        chk_int("R8", pulses - base, 0);
        trig_in = 0; step(4);

        cur_req = "R10";
        base = pulses;
        @(negedge clk);
        glob_wr = 1; glob_mode = 3'd1; glob_fall = 0; glob_burst = 0;
        @(negedge clk);
        glob_wr = 0;
        chk("R10", start_a, 1'b1);
        chk("R10", start_b, 1'b1);
        step(1);
        chk("R10", start_b, 1'b0);
        @(negedge clk);
        glob_wr = 1; glob_mode = 3'd1; ctrl_wr = 1; ctrl_mode = 3'd0; ctrl_burst = 0;
        @(negedge clk);
        glob_wr = 0; ctrl_wr = 0;
        chk("R10", start_a, 1'b1);
        @(negedge clk);
        glob_wr = 1; glob_mode = 3'd1; glob_burst = 1; ctrl_wr = 1; ctrl_mode = 3'd1;
        @(negedge clk);
        glob_wr = 0; ctrl_wr = 0; glob_burst = 0;
        chk("R10", start_a, 1'b0);
        step(3);
        chk_int("R10", pulses - base, 2);

        cur_req = "R11";
        trig_in = 0;
        wr_local(3'd4, 1'b0, 1'b0);
        step(4);
        base = pulses;
        trig_in = 6'h04; step(25);
        chk_int("R11", pulses - base, 1);
        trig_in = 0; step(6);
        trig_in = 6'h04; step(6);
        chk_int("R11", pulses - base, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule